// File: doc/BRIEF.md
# Indexed Address Generator with Pair Post-Increment

This block turns a register index from an indexed load or store into a 16-bit memory address. The address is built from a pair of 8-bit registers: an even register and the one above it. The register file returns the two bytes for the pair that the block selects. The block then presents the address to memory on a valid/ready stream.

When the `AUTO_INC` build parameter is set, an indexed access that names an odd register works differently. It uses the pair that starts at the next lower even register. Once memory has accepted the access, the block bumps that pair by one as a 16-bit value. It does this through a one-cycle write-back port that carries the new low and high bytes. Even indices never trigger the bump, so code that only names even indices behaves the same either way.

The request side is also valid/ready, with a one-entry holding slot:
- A request is taken only while `req_ready` is high.
- `req_ready` drops while an address waits for memory and during the write-back cycle. This way, a request that follows never reads a pair that is about to change.
- On the memory side, `mem_addr` stays frozen for as long as `mem_valid` is high and `mem_ready` is low.

Top module: `idx_addr_gen`

## Requirements
- R1: For an accepted indexed request, `mem_addr` equals `{rf_hi_data, rf_lo_data}` sampled at acceptance. The high byte comes from the higher-numbered register and the low byte from the even register given on `rf_pair_sel`.
- R2: An even `req_reg_idx` produces an address with no write-back.
- R3: With `AUTO_INC`=1, an odd index selects the pair whose base is the index with bit 0 cleared. `wb_pair_sel` equals that even base.
- R4: The post-increment works as follows. `mem_addr` carries the value before the increment. The write-back carries that value plus one, with the carry from the low byte going into the high byte.
- R5: Incrementing 16'hFFFF wraps to 16'h0000.
- R6: A request with `req_is_indexed`=0 produces neither a memory request nor a write-back.
- R7: With `AUTO_INC`=0, an odd index addresses the same pair as the even index below it, and `wb_en` never rises.
- R8: Back-pressure rules:
  - While `mem_valid` is high and `mem_ready` is low, `mem_valid` stays high and `mem_addr` stays unchanged.
  - `req_ready` is low while `mem_valid` or `wb_en` is high.
- R9: `wb_en` is a single-cycle pulse. It comes in the cycle after the memory handshake of a post-increment access.
- R10: After reset, `mem_valid`=0, `wb_en`=0 and `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request slot free |
| req_is_indexed | input | 1 | 1 = indexed load/store class, 0 = other instruction |
| req_reg_idx | input | IDX_W | Register index named by the instruction |
| rf_pair_sel | output | IDX_W | Even base register of the pair to read |
| rf_lo_data | input | REG_W | Contents of the base register |
| rf_hi_data | input | REG_W | Contents of base+1 |
| mem_valid | output | 1 | Address valid toward memory |
| mem_ready | input | 1 | Memory accepts the address |
| mem_addr | output | 2*REG_W | Effective address |
| wb_en | output | 1 | Write-back strobe for the pair |
| wb_pair_sel | output | IDX_W | Even base register to write |
| wb_lo_data | output | REG_W | Incremented low byte |
| wb_hi_data | output | REG_W | Incremented high byte |

## Verification
Several request patterns are used, and each one separates a different fault:
- **Even indices** show that a plain address is formed with no write-back.
- **Odd indices** show that the pair base is chosen correctly and that the increment comes after the access.
- **A low byte of 8'hFF** exposes a missing carry into the high byte.
- **An all-ones pair** exposes a missing wrap to zero.
- **Non-indexed requests** check that other instruction classes are ignored.
- **A second instance built without the option** shows that odd indices only alias down.

All of this runs twice: once with memory always ready and once with pseudo-random stalls, which tests address hold and request blocking.

// File: rtl/idx_pkg.sv
package idx_pkg;
  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_HOLD = 2'd1,
    SLOT_WB   = 2'd2
  } slot_state_t;
endpackage

// File: rtl/idx_pair_decode.sv
module idx_pair_decode #(
  parameter int IDX_W    = 3,
  parameter bit AUTO_INC = 1'b1
) (
  input  logic [IDX_W-1:0] reg_idx,
  input  logic             is_indexed,
  output logic [IDX_W-1:0] pair_base,
  output logic             want_inc
);
  // The pair always starts on an even register.
  assign pair_base = {reg_idx[IDX_W-1:1], 1'b0};
  // An increment is requested only for an odd index in the indexed class, and only when built in.
  assign want_inc  = AUTO_INC && reg_idx[0] && is_indexed;
endmodule

// File: rtl/idx_incr.sv
module idx_incr #(
  parameter int REG_W = 8,
  parameter int NLANE = 2
) (
  input  logic [REG_W*NLANE-1:0] val_in,
  output logic [REG_W*NLANE-1:0] val_out
);
  logic [NLANE-1:0] carry;
  assign carry[0] = 1'b1;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic [REG_W-1:0] lane_in;
    logic [REG_W-1:0] lane_out;
    assign lane_in = val_in[g*REG_W +: REG_W];
    if (g < NLANE - 1) begin : g_mid
      // A lower lane passes its carry to the lane above.
      assign {carry[g+1], lane_out} = {1'b0, lane_in} + {{REG_W{1'b0}}, carry[g]};
    end else begin : g_top
      // The carry out of the top lane is dropped, so all ones wraps to zero.
      assign lane_out = lane_in + {{(REG_W-1){1'b0}}, carry[g]};
    end
    assign val_out[g*REG_W +: REG_W] = lane_out;
  end
endmodule

// File: rtl/idx_addr_slot.sv
module idx_addr_slot
  import idx_pkg::*;
#(
  parameter int AW    = 16,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             is_indexed,
  input  logic             want_inc,
  input  logic [IDX_W-1:0] pair_base,
  input  logic [AW-1:0]    addr_in,
  output logic             slot_free,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [AW-1:0]    addr_q,
  output logic             wb_pulse,
  output logic [IDX_W-1:0] base_q
);
  slot_state_t state_q, state_d;
  logic        inc_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SLOT_IDLE: if (take && is_indexed) state_d = SLOT_HOLD;
      SLOT_HOLD: if (out_ready)          state_d = inc_q ? SLOT_WB : SLOT_IDLE;
      SLOT_WB:                           state_d = SLOT_IDLE;
      default:                           state_d = SLOT_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SLOT_IDLE;
      inc_q   <= 1'b0;
      addr_q  <= '0;
      base_q  <= '0;
    end else begin
      state_q <= state_d;
      // The address and pair base are captured only when an indexed request is accepted.
      if (state_q == SLOT_IDLE && take && is_indexed) begin
        addr_q <= addr_in;
        base_q <= pair_base;
        inc_q  <= want_inc;
      end
    end
  end

  assign slot_free = (state_q == SLOT_IDLE);
  assign out_valid = (state_q == SLOT_HOLD);
  assign wb_pulse  = (state_q == SLOT_WB);
endmodule

// File: rtl/idx_addr_gen.sv
module idx_addr_gen #(
  parameter int REG_W    = 8,
  parameter int IDX_W    = 3,
  parameter bit AUTO_INC = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_is_indexed,
  input  logic [IDX_W-1:0]   req_reg_idx,
  output logic [IDX_W-1:0]   rf_pair_sel,
  input  logic [REG_W-1:0]   rf_lo_data,
  input  logic [REG_W-1:0]   rf_hi_data,
  output logic               mem_valid,
  input  logic               mem_ready,
  output logic [2*REG_W-1:0] mem_addr,
  output logic               wb_en,
  output logic [IDX_W-1:0]   wb_pair_sel,
  output logic [REG_W-1:0]   wb_lo_data,
  output logic [REG_W-1:0]   wb_hi_data
);
  localparam int AW = 2 * REG_W;

  logic             take;
  logic             want_inc;
  logic [IDX_W-1:0] pair_base;
  logic [AW-1:0]    addr_bumped;

  idx_pair_decode #(.IDX_W(IDX_W), .AUTO_INC(AUTO_INC)) u_dec (
    .reg_idx    (req_reg_idx),
    .is_indexed (req_is_indexed),
    .pair_base  (pair_base),
    .want_inc   (want_inc)
  );

  assign rf_pair_sel = pair_base;
  assign take        = req_valid && req_ready;

  idx_addr_slot #(.AW(AW), .IDX_W(IDX_W)) u_slot (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .is_indexed (req_is_indexed),
    .want_inc   (want_inc),
    .pair_base  (pair_base),
    .addr_in    ({rf_hi_data, rf_lo_data}),
    .slot_free  (req_ready),
    .out_valid  (mem_valid),
    .out_ready  (mem_ready),
    .addr_q     (mem_addr),
    .wb_pulse   (wb_en),
    .base_q     (wb_pair_sel)
  );

  // The bump is applied to the held address, which keeps the value from before the access.
  idx_incr #(.REG_W(REG_W), .NLANE(2)) u_inc (
    .val_in  (mem_addr),
    .val_out (addr_bumped)
  );

  assign wb_lo_data = addr_bumped[REG_W-1:0];
  assign wb_hi_data = addr_bumped[AW-1:REG_W];
endmodule

// File: rtl/idx_addr_gen_chk.sv
module idx_addr_gen_chk #(
  parameter int REG_W    = 8,
  parameter int IDX_W    = 3,
  parameter bit AUTO_INC = 1'b1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_is_indexed,
  input logic               mem_valid,
  input logic               mem_ready,
  input logic [2*REG_W-1:0] mem_addr,
  input logic               wb_en,
  input logic [IDX_W-1:0]   wb_pair_sel,
  input logic [REG_W-1:0]   wb_lo_data,
  input logic [REG_W-1:0]   wb_hi_data
);
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));
  // R8
  req_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid || wb_en) |-> !req_ready);
  // R9
  wb_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> $past(mem_valid && mem_ready));
  // R9
  wb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |=> !wb_en);
  // R4
  wb_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> ({wb_hi_data, wb_lo_data} == $past(mem_addr) + 1'b1));
  // R3
  wb_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> !wb_pair_sel[0]);
  // R6
  other_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_is_indexed) |=> !mem_valid);
  // R7
  no_wb_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (AUTO_INC == 1'b0) |-> !wb_en);
endmodule

bind idx_addr_gen idx_addr_gen_chk #(.REG_W(REG_W), .IDX_W(IDX_W), .AUTO_INC(AUTO_INC)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .req_is_indexed (req_is_indexed),
  .mem_valid      (mem_valid),
  .mem_ready      (mem_ready),
  .mem_addr       (mem_addr),
  .wb_en          (wb_en),
  .wb_pair_sel    (wb_pair_sel),
  .wb_lo_data     (wb_lo_data),
  .wb_hi_data     (wb_hi_data)
);

// File: tb/tb_idx_addr_gen.sv
module tb_idx_addr_gen;
  logic clk = 1'b0;
  always #5 clk = ~clk;
  logic rst_n = 1'b0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [7:0] rf [8];
  logic [7:0] model [8];

  // Main instance with the increment option built in.
  logic        req_valid = 1'b0, req_is_indexed = 1'b0;
  logic [2:0]  req_reg_idx = '0;
  logic        req_ready, mem_valid, wb_en;
  logic        mem_ready = 1'b1;
  logic [2:0]  rf_pair_sel, wb_pair_sel;
  logic [15:0] mem_addr;
  logic [7:0]  wb_lo_data, wb_hi_data;

  idx_addr_gen #(.REG_W(8), .IDX_W(3), .AUTO_INC(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_is_indexed(req_is_indexed), .req_reg_idx(req_reg_idx),
    .rf_pair_sel(rf_pair_sel), .rf_lo_data(rf[rf_pair_sel]),
    .rf_hi_data(rf[rf_pair_sel + 3'd1]), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .wb_en(wb_en),
    .wb_pair_sel(wb_pair_sel), .wb_lo_data(wb_lo_data), .wb_hi_data(wb_hi_data));

  // Second instance built without the option.
  logic        n_req_valid = 1'b0;
  logic [2:0]  n_idx = '0;
  logic        n_req_ready, n_mem_valid, n_wb_en;
  logic [2:0]  n_sel, n_wb_sel;
  logic [15:0] n_addr;
  logic [7:0]  n_wb_lo, n_wb_hi;
  int          n_wb_seen = 0;

  idx_addr_gen #(.REG_W(8), .IDX_W(3), .AUTO_INC(1'b0)) dut_noinc (
    .clk(clk), .rst_n(rst_n), .req_valid(n_req_valid), .req_ready(n_req_ready),
    .req_is_indexed(1'b1), .req_reg_idx(n_idx),
    .rf_pair_sel(n_sel), .rf_lo_data(rf[n_sel]), .rf_hi_data(rf[n_sel + 3'd1]),
    .mem_valid(n_mem_valid), .mem_ready(1'b1), .mem_addr(n_addr), .wb_en(n_wb_en),
    .wb_pair_sel(n_wb_sel), .wb_lo_data(n_wb_lo), .wb_hi_data(n_wb_hi));

  // Register file model: write-backs from the main instance land here.
  always @(posedge clk) begin
    if (wb_en) begin
      rf[wb_pair_sel]        <= wb_lo_data;
      rf[wb_pair_sel + 3'd1] <= wb_hi_data;
    end
  end

  // Memory-side stall generator; values change at the rising edge only.
  bit        stall_mode = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_ready <= stall_mode ? lfsr[0] : 1'b1;
  end

  typedef struct packed { logic [2:0] sel; logic [15:0] val; } wb_item_t;
  logic [15:0] addr_q [$];
  wb_item_t    wb_q [$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: issues one request and pushes what the requirements predict.
  task automatic send(input bit cls, input logic [2:0] idx);
    logic [2:0]  base;
    logic [15:0] a;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_is_indexed = cls; req_reg_idx = idx;
    base = {idx[2:1], 1'b0};
    a = {model[base + 3'd1], model[base]};
    if (cls) begin
      addr_q.push_back(a);                       // R1, R2
      if (idx[0]) begin                          // R3, R4, R5
        wb_q.push_back('{sel: base, val: a + 16'd1});
        model[base] = a[7:0] + 8'd1;
        model[base + 3'd1] = (a + 16'd1) >> 8;
      end
    end                                          // R6: nothing expected
    @(negedge clk);
    req_valid = 1'b0; req_is_indexed = 1'b0;
  endtask

  // Monitor: pops and compares as results appear.
  logic        prev_stall = 1'b0;
  logic [15:0] prev_addr = '0;
  logic        prev_wb = 1'b0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (mem_valid) begin
        chk(!req_ready, "R8 req_ready low while busy", {31'd0, req_ready}, 32'd0);
        if (prev_stall)
          chk(mem_addr == prev_addr, "R8 addr held", {16'd0, mem_addr}, {16'd0, prev_addr});
        if (mem_ready) begin
          if (addr_q.size() == 0)
            chk(1'b0, "R6 unexpected address", {16'd0, mem_addr}, 32'd0);
          else begin
            logic [15:0] e;
            e = addr_q.pop_front();
            chk(mem_addr == e, "R1 address", {16'd0, mem_addr}, {16'd0, e});
          end
        end
      end
      if (wb_en) begin
        chk(!prev_wb, "R9 single-cycle pulse", 32'd1, 32'd0);
        if (wb_q.size() == 0)
          chk(1'b0, "R2 unexpected write-back", {13'd0, wb_pair_sel, wb_hi_data, wb_lo_data}, 32'd0);
        else begin
          wb_item_t w;
          w = wb_q.pop_front();
          chk(wb_pair_sel == w.sel, "R3 pair base", {29'd0, wb_pair_sel}, {29'd0, w.sel});
          chk({wb_hi_data, wb_lo_data} == w.val, "R4 R5 incremented value",
              {16'd0, wb_hi_data, wb_lo_data}, {16'd0, w.val});
        end
      end
      prev_stall = mem_valid && !mem_ready;
      prev_addr  = mem_addr;
      prev_wb    = wb_en;
      if (n_wb_en) n_wb_seen++;
    end
  end

  task automatic drain();
    int k = 0;
    while ((addr_q.size() != 0 || wb_q.size() != 0 || !req_ready) && k < 200) begin
      @(negedge clk); k++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      rf[i] = 8'h10 * i[7:0] + 8'h3;
      model[i] = rf[i];
    end
    rf[2] = 8'hFF; rf[3] = 8'hFF; model[2] = 8'hFF; model[3] = 8'hFF;
    rf[4] = 8'hFF; rf[5] = 8'h12; model[4] = 8'hFF; model[5] = 8'h12;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(!mem_valid, "R10 mem_valid after reset", {31'd0, mem_valid}, 32'd0);
    chk(!wb_en, "R10 wb_en after reset", {31'd0, wb_en}, 32'd0);
    chk(req_ready, "R10 req_ready after reset", {31'd0, req_ready}, 32'd1);

    for (int pass = 0; pass < 2; pass++) begin
      stall_mode = (pass == 1);
      send(1'b1, 3'd0);   // R2 even
      send(1'b1, 3'd6);   // R2 even
      send(1'b1, 3'd1);   // R3 odd, pair 0
      send(1'b1, 3'd1);
      send(1'b0, 3'd1);   // R6 other class
      send(1'b1, 3'd0);   // R4 sees bumped pair
      send(1'b1, 3'd5);   // R4 carry FF -> next byte
      send(1'b1, 3'd4);
      send(1'b1, 3'd3);   // R5 wrap
      send(1'b1, 3'd2);
      send(1'b0, 3'd6);   // R6
      send(1'b1, 3'd7);
      drain();
    end
    chk(addr_q.size() == 0 && wb_q.size() == 0, "R1 all results seen",
        addr_q.size() + wb_q.size(), 32'd0);
    for (int i = 0; i < 8; i++)
      chk(rf[i] == model[i], "R4 register pair contents", {24'd0, rf[i]}, {24'd0, model[i]});

    // R7: instance without the option aliases odd down and never writes back.
    for (int j = 0; j < 4; j++) begin
      logic [2:0]  idx;
      logic [15:0] e;
      idx = 3'(2 * j + 1);
      @(negedge clk);
      while (!n_req_ready) @(negedge clk);
      n_req_valid = 1'b1; n_idx = idx;
      e = {rf[idx], rf[idx - 3'd1]};
      @(negedge clk);
      n_req_valid = 1'b0;
      chk(n_mem_valid && n_addr == e, "R7 odd index aliases even", {16'd0, n_addr}, {16'd0, e});
      repeat (3) @(negedge clk);
    end
    chk(n_wb_seen == 0, "R7 no write-back", n_wb_seen, 32'd0);
    finish_run();
  end
endmodule